// File: doc/BRIEF.md
# Thermal Operating-Point Transition Controller

This block moves a processor core between two operating points, a normal one and a reduced one. Each point is a clock ratio paired with a voltage identification code that goes to the supply regulator. When the controller is enabled and the over-temperature flag rises, it first switches the clock ratio. While the clock generator relocks it holds off bus traffic. After the new frequency is running, it walks the voltage code down one code at a time with a minimum spacing between codes. Instruction execution continues during that walk.

Recovery runs in the reverse order. The flag must stay low until a hysteresis down-counter has run out. The voltage code then climbs back to the normal value, and only after it arrives is the normal clock ratio restored, again behind a bus hold-off window. If the flag returns during the climb, the controller turns round and walks the voltage back down without touching the frequency. Clearing the enable sends the controller home through the same recovery order, with no hysteresis wait. Edge-triggered interrupts that arrive while the bus is held off are captured in a pending register, and each bit stays set until it is acknowledged.

The clock generator, the regulator and the temperature sensor sit outside the block. The block sees them only through the relock request and done handshake, the voltage code output and the temperature flag. All timing is counted in `tick` pulses.

Top module: `thermal_opp_seq`

## Requirements
- R1: After reset, `bus_block`, `relock_req` and `irq_pend` are 0. While the controller is at the normal point, `cur_ratio` follows `norm_ratio` and `vid_out` follows `norm_vid`.
- R2: At the normal point, with `en`=1 and `temp_hi`=1, `cur_ratio` changes to `low_ratio` on the same clock edge that raises `bus_block`. `vid_out` does not change while `bus_block` is 1.
- R3: A frequency window, whether throttling or restoring, keeps `bus_block` and `relock_req` both at 1 for at least `FREQ_TICKS` ticks. When `USE_RELOCK`=1 the window also lasts until `relock_done` is seen high.
- R4: After the throttle window, `vid_out` moves toward `low_vid` by exactly one code per change, passing every intermediate code, with `bus_block`=0.
- R5: Any two successive changes of `vid_out` are at least `STEP_TICKS` ticks apart.
- R6: From the reduced point, recovery starts only after `temp_hi` has been 0 for `HYST_TICKS` consecutive ticks. Any tick-window with `temp_hi`=1 reloads the count.
- R7: During recovery `vid_out` climbs one code at a time to `norm_vid` while `cur_ratio` stays at `low_ratio`. Only after that does `cur_ratio` return to `norm_ratio`, inside a `bus_block` window.
- R8: If `temp_hi` rises while the voltage is climbing, `vid_out` turns back toward `low_vid`, with no ratio change and no `bus_block`.
- R9: With `en`=0 in any reduced state, the controller recovers in the order of R7 without waiting for hysteresis, whatever the value of `temp_hi`.
- R10: A rising edge on `irq_in[i]` while `bus_block`=1 sets `irq_pend[i]`. Rising edges while `bus_block`=0 do not set it. A set bit clears only on the clock after `irq_ack[i]`=1, and a capture in the same cycle wins over the acknowledge.
- R11: With `en`=0, `temp_hi` has no effect at the normal point: the ratio and voltage code stay at normal values and `bus_block` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe; all intervals are counted in ticks |
| en | input | 1 | Throttling enable |
| temp_hi | input | 1 | Over-temperature flag |
| norm_ratio | input | RATIO_W | Clock ratio of the normal point |
| low_ratio | input | RATIO_W | Clock ratio of the reduced point |
| norm_vid | input | VID_W | Voltage code of the normal point |
| low_vid | input | VID_W | Voltage code of the reduced point |
| relock_done | input | 1 | Clock generator reports lock at the new ratio |
| irq_in | input | IRQ_W | Edge-triggered interrupt lines |
| irq_ack | input | IRQ_W | Per-line acknowledge of pending interrupts |
| cur_ratio | output | RATIO_W | Clock ratio in force |
| vid_out | output | VID_W | Voltage code sent to the regulator |
| bus_block | output | 1 | Bus requests are held off |
| relock_req | output | 1 | Request to the clock generator to relock |
| irq_pend | output | IRQ_W | Interrupts captured during bus hold-off |

## Verification
The bound checker watches four things on every cycle: the single-code size of every voltage change, the frozen voltage code during bus hold-off, ratio changes happening only inside a hold-off window, and the minimum tick length of each window. It also checks that pending interrupt bits are set only under hold-off and cleared only by an acknowledge. The order of whole sequences is left to the bench scenarios. These cover frequency before voltage, voltage before frequency on the way back, the reversal mid-climb, the hysteresis wait including its reload by a short flag blip, and the disable path that skips it. The bench also covers the delay imposed by the external relock handshake and the spacing of voltage codes measured in clock cycles.

// File: rtl/topp_pkg.sv
package topp_pkg;
  typedef enum logic [2:0] {
    ST_NORM  = 3'd0,
    ST_FDOWN = 3'd1,
    ST_VDOWN = 3'd2,
    ST_LOW   = 3'd3,
    ST_VUP   = 3'd4,
    ST_FUP   = 3'd5
  } opp_state_e;
endpackage

// File: rtl/topp_win_timer.sv
// Frequency-change window: at least FREQ_TICKS ticks, plus relock if enabled.
module topp_win_timer #(
  parameter int FREQ_TICKS = 4,
  parameter bit USE_RELOCK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic relock_done,
  output logic done
);
  localparam int WIN_W = $clog2(FREQ_TICKS + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(FREQ_TICKS);

  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic             relock_ok;

  assign relock_ok = relock_done | !USE_RELOCK;

  always_comb begin
    cnt_d = cnt_q;
    if (!active)
      cnt_d = '0;
    else if (tick && cnt_q != WIN_END)
      cnt_d = cnt_q + WIN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = active && (cnt_q == WIN_END) && relock_ok;
endmodule

// File: rtl/topp_hyst_timer.sv
// Hysteresis down-counter: reloads while flag high or disarmed.
module topp_hyst_timer #(
  parameter int HYST_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic temp_hi,
  output logic expired
);
  localparam int HW = $clog2(HYST_TICKS + 1);
  localparam logic [HW-1:0] RELOAD = HW'(HYST_TICKS);

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (temp_hi || !arm)
      cnt_d = RELOAD;
    else if (tick && cnt_q != '0)
      cnt_d = cnt_q - HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/topp_vid_stepper.sv
// Voltage code walker: one code per step, STEP_TICKS ticks apart.
module topp_vid_stepper #(
  parameter int VID_W      = 6,
  parameter int STEP_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [VID_W-1:0] load_val,
  input  logic             run,
  input  logic [VID_W-1:0] target,
  output logic [VID_W-1:0] vid,
  output logic             at_target
);
  localparam int GW = $clog2(STEP_TICKS + 1);
  localparam logic [GW-1:0] GAP_RELOAD = GW'(STEP_TICKS - 1);

  logic [VID_W-1:0] vid_q, vid_d;
  logic [GW-1:0]    gap_q, gap_d;
  logic             step_en, go_up;

  assign at_target = (vid_q == target);
  assign go_up     = (target > vid_q);
  assign step_en   = run && !at_target && tick && (gap_q == '0);

  always_comb begin
    vid_d = vid_q;
    gap_d = gap_q;
    if (load) begin
      vid_d = load_val;
      gap_d = '0;
    end else if (tick) begin
      if (step_en) begin
        vid_d = go_up ? vid_q + VID_W'(1) : vid_q - VID_W'(1);
        gap_d = GAP_RELOAD;
      end else if (gap_q != '0) begin
        gap_d = gap_q - GW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_q <= '0;
      gap_q <= '0;
    end else begin
      vid_q <= vid_d;
      gap_q <= gap_d;
    end
  end

  assign vid = vid_q;
endmodule

// File: rtl/topp_irq_latch.sv
// Captures interrupt rising edges during bus hold-off until acknowledged.
module topp_irq_latch #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [IRQ_W-1:0] irq_in,
  input  logic [IRQ_W-1:0] irq_ack,
  output logic [IRQ_W-1:0] pend
);
  logic [IRQ_W-1:0] prev_q;
  logic [IRQ_W-1:0] pend_q;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_line
    logic rise, set_d;
    assign rise  = irq_in[i] && !prev_q[i];
    assign set_d = (capture && rise) || (pend_q[i] && !irq_ack[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= irq_in[i];
        pend_q[i] <= set_d;
      end
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/thermal_opp_seq.sv
module thermal_opp_seq
  import topp_pkg::*;
#(
  parameter int RATIO_W    = 8,
  parameter int VID_W      = 6,
  parameter int IRQ_W      = 4,
  parameter int FREQ_TICKS = 4,
  parameter int STEP_TICKS = 2,
  parameter int HYST_TICKS = 8,
  parameter bit USE_RELOCK = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               en,
  input  logic               temp_hi,
  input  logic [RATIO_W-1:0] norm_ratio,
  input  logic [RATIO_W-1:0] low_ratio,
  input  logic [VID_W-1:0]   norm_vid,
  input  logic [VID_W-1:0]   low_vid,
  input  logic               relock_done,
  input  logic [IRQ_W-1:0]   irq_in,
  input  logic [IRQ_W-1:0]   irq_ack,
  output logic [RATIO_W-1:0] cur_ratio,
  output logic [VID_W-1:0]   vid_out,
  output logic               bus_block,
  output logic               relock_req,
  output logic [IRQ_W-1:0]   irq_pend
);
  opp_state_e         state_q, state_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               in_window, win_done;
  logic               hyst_arm, hyst_expired;
  logic               step_run, at_target;
  logic [VID_W-1:0]   step_target;

  assign in_window   = (state_q == ST_FDOWN) || (state_q == ST_FUP);
  assign hyst_arm    = (state_q == ST_VDOWN) || (state_q == ST_LOW);
  assign step_run    = (state_q == ST_VDOWN) || (state_q == ST_VUP);
  assign step_target = (state_q == ST_VUP) ? norm_vid : low_vid;

  topp_win_timer #(
    .FREQ_TICKS(FREQ_TICKS),
    .USE_RELOCK(USE_RELOCK)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (in_window),
    .tick       (tick),
    .relock_done(relock_done),
    .done       (win_done)
  );

  topp_hyst_timer #(
    .HYST_TICKS(HYST_TICKS)
  ) u_hyst (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .arm    (hyst_arm),
    .temp_hi(temp_hi),
    .expired(hyst_expired)
  );

  topp_vid_stepper #(
    .VID_W     (VID_W),
    .STEP_TICKS(STEP_TICKS)
  ) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (state_q == ST_NORM),
    .load_val (norm_vid),
    .run      (step_run),
    .target   (step_target),
    .vid      (vid_out),
    .at_target(at_target)
  );

  topp_irq_latch #(
    .IRQ_W(IRQ_W)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(in_window),
    .irq_in (irq_in),
    .irq_ack(irq_ack),
    .pend   (irq_pend)
  );

  // Next-state: frequency first going down, voltage first coming back.
  always_comb begin
    state_d = state_q;
    ratio_d = ratio_q;
    unique case (state_q)
      ST_NORM: begin
        ratio_d = norm_ratio;
        if (en && temp_hi) begin
          state_d = ST_FDOWN;
          ratio_d = low_ratio;
        end
      end
      ST_FDOWN: begin
        if (win_done) state_d = ST_VDOWN;
      end
      ST_VDOWN: begin
        if (!en)            state_d = ST_VUP;
        else if (at_target) state_d = ST_LOW;
      end
      ST_LOW: begin
        if (!en || (!temp_hi && hyst_expired)) state_d = ST_VUP;
      end
      ST_VUP: begin
        if (en && temp_hi) begin
          state_d = ST_VDOWN;
        end else if (at_target) begin
          state_d = ST_FUP;
          ratio_d = norm_ratio;
        end
      end
      ST_FUP: begin
        if (win_done) state_d = ST_NORM;
      end
      default: state_d = ST_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORM;
      ratio_q <= '0;
    end else begin
      state_q <= state_d;
      ratio_q <= ratio_d;
    end
  end

  assign cur_ratio  = ratio_q;
  assign bus_block  = in_window;
  assign relock_req = in_window;
endmodule

// File: rtl/topp_checker.sv
module topp_checker
  import topp_pkg::*;
#(
  parameter int RATIO_W    = 8,
  parameter int VID_W      = 6,
  parameter int IRQ_W      = 4,
  parameter int FREQ_TICKS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input opp_state_e         state_q,
  input logic [RATIO_W-1:0] cur_ratio,
  input logic [VID_W-1:0]   vid_out,
  input logic               bus_block,
  input logic [IRQ_W-1:0]   irq_pend,
  input logic [IRQ_W-1:0]   irq_ack
);
  localparam int BW = $clog2(FREQ_TICKS + 1);
  localparam logic [BW-1:0] BMAX = BW'(FREQ_TICKS);

  logic [BW-1:0] blk_ticks;
  logic          blk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_ticks <= '0;
      blk_d     <= 1'b0;
    end else begin
      blk_d <= bus_block;
      if (!bus_block)
        blk_ticks <= '0;
      else if (tick && blk_ticks != BMAX)
        blk_ticks <= blk_ticks + BW'(1);
    end
  end

  AST_VID_ONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != ST_NORM && vid_out != $past(vid_out)) |->
      (vid_out == $past(vid_out) + VID_W'(1) || $past(vid_out) == vid_out + VID_W'(1))); // R4

  AST_VID_FROZEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_block && $past(bus_block)) |-> $stable(vid_out)); // R2

  AST_RATIO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != ST_NORM && !$stable(cur_ratio)) |-> bus_block); // R7

  AST_WINDOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_block) |-> (blk_ticks == BMAX)); // R3

  AST_PEND_CLEAR_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_pend) & ~irq_pend & ~$past(irq_ack)) == '0)); // R10

  AST_PEND_SET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_d |-> ((irq_pend & ~$past(irq_pend)) == '0)); // R10
endmodule

bind thermal_opp_seq topp_checker #(
  .RATIO_W   (RATIO_W),
  .VID_W     (VID_W),
  .IRQ_W     (IRQ_W),
  .FREQ_TICKS(FREQ_TICKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .state_q  (state_q),
  .cur_ratio(cur_ratio),
  .vid_out  (vid_out),
  .bus_block(bus_block),
  .irq_pend (irq_pend),
  .irq_ack  (irq_ack)
);

// File: tb/thermal_opp_seq_test.sv
`timescale 1ns/100ps
module thermal_opp_seq_test;
  localparam int RW = 8, VW = 6, IW = 4;
  localparam int FT = 3, ST = 2, HT = 6;
  localparam int RELOCK_DLY = 10;
  localparam logic [RW-1:0] NR = 8'd20, LR = 8'd14;
  localparam logic [VW-1:0] NV = 6'd10, LV = 6'd6;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, en = 1'b0, temp_hi = 1'b0;
  logic relock_done = 1'b0;
  logic [IW-1:0] irq_in = '0, irq_ack = '0;
  logic [RW-1:0] cur_ratio;
  logic [VW-1:0] vid_out;
  logic bus_block, relock_req;
  logic [IW-1:0] irq_pend;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  typedef struct packed {logic [RW-1:0] r; logic [VW-1:0] v; logic b;} pt_t;
  pt_t   exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  thermal_opp_seq #(
    .RATIO_W(RW), .VID_W(VW), .IRQ_W(IW),
    .FREQ_TICKS(FT), .STEP_TICKS(ST), .HYST_TICKS(HT), .USE_RELOCK(1'b1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .temp_hi(temp_hi),
    .norm_ratio(NR), .low_ratio(LR), .norm_vid(NV), .low_vid(LV),
    .relock_done(relock_done), .irq_in(irq_in), .irq_ack(irq_ack),
    .cur_ratio(cur_ratio), .vid_out(vid_out), .bus_block(bus_block),
    .relock_req(relock_req), .irq_pend(irq_pend)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Driver side of the scoreboard: push the expected output points.
  task automatic expect_pt(input logic [RW-1:0] r, input logic [VW-1:0] v,
                           input logic b, input string tag);
    exp_q.push_back('{r: r, v: v, b: b});
    tag_q.push_back(tag);
  endtask

  task automatic push_throttle();
    expect_pt(LR, NV, 1'b1, "R2");
    expect_pt(LR, NV, 1'b0, "R3");
    for (int v = NV - 1; v >= LV; v--) expect_pt(LR, VW'(v), 1'b0, "R4");
  endtask

  task automatic push_climb(input int from_v);
    for (int v = from_v + 1; v <= NV; v++) expect_pt(LR, VW'(v), 1'b0, "R7");
    expect_pt(NR, NV, 1'b1, "R7");
    expect_pt(NR, NV, 1'b0, "R7");
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Timebase: one tick every two clocks.
  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  // Clock-generator model: relock completes RELOCK_DLY cycles after request.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (!relock_req) begin
        relock_done = 1'b0;
        cnt = 0;
      end else if (!relock_done) begin
        cnt++;
        if (cnt >= RELOCK_DLY) relock_done = 1'b1;
      end
    end
  end

  // Monitor side of the scoreboard.
  initial begin
    pt_t last, cur;
    last = '0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      cur = '{r: cur_ratio, v: vid_out, b: bus_block};
      if (cur != last) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected output change", int'(cur), int'(last));
        end else begin
          pt_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cur == e, t, int'(cur), int'(e));
        end
        last = cur;
      end
    end
  end

  // R3: window length and relock request held throughout the window.
  initial begin
    int len = 0;
    bit req_ok = 1'b1;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (bus_block) begin
        len++;
        if (!relock_req) req_ok = 1'b0;
      end else if (len != 0) begin
        check(len >= RELOCK_DLY, "R3 window length", len, RELOCK_DLY);
        check(req_ok, "R3 relock_req during window", int'(req_ok), 1);
        len = 0;
        req_ok = 1'b1;
      end
    end
  end

  // R5: spacing of successive voltage code changes (2 clocks per tick).
  initial begin
    logic [VW-1:0] pv;
    int since = 0;
    bit seen = 1'b0;
    wait (rst_n);
    @(negedge clk);
    @(negedge clk);
    pv = vid_out;
    forever begin
      @(negedge clk);
      since++;
      if (vid_out != pv) begin
        if (seen) check(since >= 2 * ST, "R5 step spacing", since, 2 * ST);
        seen = 1'b1;
        since = 0;
        pv = vid_out;
      end
    end
  end

  initial begin
    cycles(50000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    expect_pt(NR, NV, 1'b0, "R1");
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    check(bus_block == 1'b0, "R1 bus_block", int'(bus_block), 0);
    check(relock_req == 1'b0, "R1 relock_req", int'(relock_req), 0);
    check(irq_pend == '0, "R1 irq_pend", int'(irq_pend), 0);

    // R11: flag ignored while disabled.
    temp_hi = 1'b1;
    cycles(40);
    check(cur_ratio == NR, "R11 ratio", int'(cur_ratio), int'(NR));
    check(bus_block == 1'b0, "R11 bus_block", int'(bus_block), 0);
    temp_hi = 1'b0;
    cycles(4);

    // R10: edge outside a window is not captured.
    irq_in[2] = 1'b1;
    cycles(2);
    irq_in[2] = 1'b0;
    cycles(2);
    check(irq_pend == '0, "R10 no capture outside window", int'(irq_pend), 0);

    // Throttle.
    push_throttle();
    en = 1'b1;
    temp_hi = 1'b1;
    while (!bus_block) @(negedge clk);
    cycles(2);
    irq_in[1] = 1'b1;
    cycles(2);
    irq_in[1] = 1'b0;
    while (bus_block) @(negedge clk);
    irq_in[3] = 1'b1;
    cycles(2);
    irq_in[3] = 1'b0;
    while (vid_out != LV) @(negedge clk);
    check(irq_pend == 4'b0010, "R10 capture in window", int'(irq_pend), 2);
    cycles(30);
    check(irq_pend == 4'b0010, "R10 held until ack", int'(irq_pend), 2);
    irq_ack[1] = 1'b1;
    @(negedge clk);
    irq_ack[1] = 1'b0;
    check(irq_pend == '0, "R10 cleared by ack", int'(irq_pend), 0);

    // R6: short blip below hysteresis must not start recovery.
    temp_hi = 1'b0;
    cycles(4);
    temp_hi = 1'b1;
    cycles(10);
    push_climb(32'(LV));
    // the climb is cut at vid 8 below; re-queue after the reversal
    exp_q.delete();
    tag_q.delete();
    expect_pt(LR, LV + 6'd1, 1'b0, "R7");
    expect_pt(LR, LV + 6'd2, 1'b0, "R7");
    expect_pt(LR, LV + 6'd1, 1'b0, "R8");
    expect_pt(LR, LV, 1'b0, "R8");
    temp_hi = 1'b0;
    n = 0;
    while (vid_out == LV) begin
      @(negedge clk);
      n++;
    end
    check(n >= 2 * HT, "R6 hysteresis wait", n, 2 * HT);
    while (vid_out != LV + 6'd2) @(negedge clk);
    temp_hi = 1'b1;
    while (vid_out != LV) @(negedge clk);
    check(cur_ratio == LR, "R8 ratio held", int'(cur_ratio), int'(LR));
    cycles(6);
    push_climb(32'(LV));
    temp_hi = 1'b0;
    while (cur_ratio != NR || bus_block) @(negedge clk);
    cycles(4);

    // R9: disable recovers without hysteresis, flag still high.
    push_throttle();
    temp_hi = 1'b1;
    while (vid_out != LV || bus_block) @(negedge clk);
    cycles(4);
    push_climb(32'(LV));
    en = 1'b0;
    n = 0;
    while (vid_out == LV) begin
      @(negedge clk);
      n++;
    end
    check(n < 2 * HT, "R9 no hysteresis wait", n, 2 * HT);
    while (cur_ratio != NR || bus_block) @(negedge clk);
    cycles(6);
    check(cur_ratio == NR, "R9 ratio restored", int'(cur_ratio), int'(NR));
    check(exp_q.size() == 0, "R7 all expected points seen", exp_q.size(), 0);
    temp_hi = 1'b0;
    cycles(4);
    finish_run();
  end
endmodule